// File: doc/BRIEF.md
# Trigger Timestamp Event Logger

This block records when trigger sources fire. It watches four channel triggers and one external trigger, all produced in a sampling clock domain. Each trigger is brought into the system clock domain by a flip-flop synchronizer and then reduced to a single-cycle rising-edge strobe. A per-source enable register gates those strobes. When one or more enabled sources rise in the same system cycle, the block builds one record and pushes it into a small first-in first-out queue. The record holds the current 40-bit seconds value, the 28-bit cycle count and a mask of the sources that fired.

Software drains the queue through a word-addressed slave register window. It polls a status word for the records-present flag. It then reads the two halves of the head record and reads the cycle word last, which removes the record from the queue. The queue shows its head record ahead of time, so the record is readable before any read strobe. The timestamp itself is an input to the block, and the link status bits are passed through to the status word.

Top module: `trig_event_log`

## Requirements
- R1: Each trigger input is synchronized through a chain of flip-flops. A trigger held high for several system cycles produces exactly one record, because only a low-to-high transition counts.
- R2: Enables are in the control word at byte address 0x04: bits 0..3 enable channels 1..4 and bit 8 enables the external trigger. The word reads back only those bits, and every other bit reads 0. After reset the control word is zero and no record is produced.
- R3: Enabled sources that rise in the same system cycle share one record. A source whose enable is clear never sets a mask bit.
- R4: The upper record word at 0x08 holds seconds bits 39:32 in bits 7:0, the channel 1..4 fired flags in bits 16..19 and the external fired flag in bit 24. The lower record word at 0x0C holds seconds bits 31:0. Reading either word does not change the queue.
- R5: The cycle word at 0x10 returns the head record's cycle count in bits 27:0. Reading it removes the head record, and the next record becomes visible at once.
- R6: The status word at 0x00 has bit 8 set while at least one record is queued. Bits 0, 1 and 2 mirror the link-enable, link-up and time-valid inputs.
- R7: The queue holds 16 records. A trigger event that finds the queue full is dropped and sets sticky status bit 9. Writing 1 to bit 9 clears it, and writing 0 leaves it unchanged.
- R8: Bits not assigned to a field read as 0. Addresses 0x14 to 0x1C read as 0. Record and cycle reads on an empty queue return 0 and remove nothing.
- R9: Every access is acknowledged exactly one cycle after its strobe, with read data valid in that cycle. Writes to the record and cycle words have no effect.
- R10: Records leave the queue in the order in which they were produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 5 | Trigger levels from the sampling domain: bits 0..3 are channels 1..4, bit 4 is external |
| ts_sec_i | input | 40 | Current seconds value |
| ts_cyc_i | input | 28 | Current cycle count within the second |
| link_en_i | input | 1 | Link enable status, mirrored in status bit 0 |
| link_up_i | input | 1 | Link up status, mirrored in status bit 1 |
| time_valid_i | input | 1 | Time valid status, mirrored in status bit 2 |
| bus_stb_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 5 | Byte address; bits 1:0 are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Access acknowledge |
| bus_rdata_o | output | 32 | Read data, valid while acknowledge is high |

## Verification
The bench sweeps all 32 enable combinations while every source fires at once. A design with a mis-wired enable or mask bit would show a wrong mask, or a record where none belongs. It then sweeps all 31 non-empty fire patterns with every source enabled; splitting simultaneous edges into several records, or firing again on a held level, would leave extra records behind. The bench fills the queue past 16 records. This catches a design that overwrites the oldest record, loses order, or fails to hold and clear the sticky drop bit. Reads on an empty queue and reads of the upper half of the record window must return zero, and the record words must hold their value across repeated reads. A design that popped on the wrong word, or kept stale read data, fails these checks.

// File: rtl/trig_log_pkg.sv
// Shared widths, record layout and register map for the trigger event logger.
// Assumes four channel sources plus one external source (source index 4).
package trig_log_pkg;

    localparam int N_CHAN  = 4;
    localparam int N_SRC   = N_CHAN + 1;
    localparam int SEC_W   = 40;
    localparam int CYC_W   = 28;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int WORD_W  = ADDR_W - 2;

    // Word indices of the register window (byte address / 4)
    localparam logic [WORD_W-1:0] W_STATUS = 3'd0;
    localparam logic [WORD_W-1:0] W_CTRL   = 3'd1;
    localparam logic [WORD_W-1:0] W_REC_HI = 3'd2;
    localparam logic [WORD_W-1:0] W_REC_LO = 3'd3;
    localparam logic [WORD_W-1:0] W_CYC    = 3'd4;

    // Bit positions that software decodes
    localparam int ST_LINK_EN  = 0;
    localparam int ST_LINK_UP  = 1;
    localparam int ST_TIME_OK  = 2;
    localparam int ST_PRESENT  = 8;
    localparam int ST_DROPPED  = 9;
    localparam int CTRL_EXT    = 8;
    localparam int HI_CH_BASE  = 16;
    localparam int HI_EXT_BIT  = 24;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [N_SRC-1:0] hit;
        logic [CYC_W-1:0] cyc;
    } trig_rec_t;

    localparam int REC_W = $bits(trig_rec_t);

    // Place a source mask into a word: channels from chan_base, external at ext_bit
    function automatic logic [DATA_W-1:0] place_mask(input logic [N_SRC-1:0] m,
                                                     input int chan_base,
                                                     input int ext_bit);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < N_CHAN; i++) begin
            w[chan_base + i] = m[i];
        end
        w[ext_bit] = m[N_CHAN];
        return w;
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
// Brings asynchronous trigger levels into the system clock domain and emits a
// one-cycle strobe for each low-to-high transition.
// Assumes each input level stays high for at least one system clock period.
module trig_edge_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);

    localparam int CHAIN = STAGES + 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [CHAIN-1:0] chain_q;

        // Shift the level through the synchronizer and one history stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], async_i[g]};
            end
        end

        // Rising edge: synchronized level high, previous level low
        assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

endmodule

// File: rtl/trig_rec_fifo.sv
// Show-ahead record queue: the head entry is on dout_o whenever the queue is
// not empty. Writes when full and reads when empty are ignored.
// Assumes DEPTH is a power of two.
module trig_rec_fifo #(
    parameter int WIDTH = 73,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [WIDTH-1:0]           din_i,
    input  logic                       pop_i,
    output logic [WIDTH-1:0]           dout_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH):0]     count_o
);

    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [AW:0]      cnt_q;
    logic             do_wr, do_rd;

    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_wr   = push_i & ~full_o;
    assign do_rd   = pop_i & ~empty_o;
    assign dout_o  = mem[rptr_q];
    assign count_o = cnt_q;

    // Store an accepted entry at the write pointer
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr_q] <= din_i;
        end
    end

    // Advance pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) wptr_q <= wptr_q + AW'(1);
            if (do_rd) rptr_q <= rptr_q + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
                2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/trig_bus_regs.sv
// Slave register window: status, enables, head-record view and pop-on-read of
// the cycle word. Acknowledges every strobe on the following cycle.
// Assumes one-cycle strobes from the requester.
module trig_bus_regs
    import trig_log_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic                  ack_o,
    output logic [DATA_W-1:0]     rdata_o,
    input  trig_rec_t             head_i,
    input  logic                  empty_i,
    input  logic                  drop_i,
    input  logic                  link_en_i,
    input  logic                  link_up_i,
    input  logic                  time_valid_i,
    output logic [N_SRC-1:0]      en_o,
    output logic                  pop_o,
    output logic                  dropped_o
);

    logic [WORD_W-1:0] word;
    logic              rd, wr;
    logic [N_SRC-1:0]  en_q;
    logic              drop_q;
    logic [DATA_W-1:0] status_w, ctrl_w, hi_w, lo_w, cyc_w, sel_w;

    assign word = addr_i[ADDR_W-1:2];
    assign rd   = stb_i & ~we_i;
    assign wr   = stb_i & we_i;

    // Pop on a read of the cycle word when a record is present
    assign pop_o     = rd & (word == W_CYC) & ~empty_i;
    assign en_o      = en_q;
    assign dropped_o = drop_q;

    // Assemble each readable word from its fields
    always_comb begin
        status_w = '0;
        status_w[ST_LINK_EN] = link_en_i;
        status_w[ST_LINK_UP] = link_up_i;
        status_w[ST_TIME_OK] = time_valid_i;
        status_w[ST_PRESENT] = ~empty_i;
        status_w[ST_DROPPED] = drop_q;

        ctrl_w = place_mask(en_q, 0, CTRL_EXT);

        hi_w = '0;
        lo_w = '0;
        cyc_w = '0;
        if (!empty_i) begin
            hi_w = place_mask(head_i.hit, HI_CH_BASE, HI_EXT_BIT);
            hi_w[SEC_W-DATA_W-1:0] = head_i.sec[SEC_W-1:DATA_W];
            lo_w = head_i.sec[DATA_W-1:0];
            cyc_w[CYC_W-1:0] = head_i.cyc;
        end
    end

    // Select the addressed word; unmapped words read as zero
    always_comb begin
        case (word)
            W_STATUS: sel_w = status_w;
            W_CTRL:   sel_w = ctrl_w;
            W_REC_HI: sel_w = hi_w;
            W_REC_LO: sel_w = lo_w;
            W_CYC:    sel_w = cyc_w;
            default:  sel_w = '0;
        endcase
    end

    // Acknowledge and return read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o   <= stb_i;
            rdata_o <= rd ? sel_w : '0;
        end
    end

    // Enable register written through the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr && word == W_CTRL) begin
            en_q <= {wdata_i[CTRL_EXT], wdata_i[N_CHAN-1:0]};
        end
    end

    // Sticky drop flag: set by a lost event, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (drop_i) begin
            drop_q <= 1'b1;
        end else if (wr && word == W_STATUS && wdata_i[ST_DROPPED]) begin
            drop_q <= 1'b0;
        end
    end

endmodule

// File: rtl/trig_event_log.sv
// Top of the trigger event logger: synchronize triggers, gate with enables,
// capture the timestamp into a record queue, expose it on the register window.
// Assumes the timestamp inputs are already in the system clock domain.
module trig_event_log
    import trig_log_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      trig_in,
    input  logic [SEC_W-1:0]      ts_sec_i,
    input  logic [CYC_W-1:0]      ts_cyc_i,
    input  logic                  link_en_i,
    input  logic                  link_up_i,
    input  logic                  time_valid_i,
    input  logic                  bus_stb_i,
    input  logic                  bus_we_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic                  bus_ack_o,
    output logic [DATA_W-1:0]     bus_rdata_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    logic [N_SRC-1:0] rise, hits, en;
    logic             push_req, fifo_full, fifo_empty, pop, dropped;
    logic [CNT_W-1:0] fifo_cnt;
    trig_rec_t        new_rec, head_rec;

    trig_edge_sync #(
        .WIDTH  (N_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_in),
        .rise_o  (rise)
    );

    // Build a record from the enabled edges of this cycle
    assign hits     = rise & en;
    assign push_req = |hits;
    always_comb begin
        new_rec.sec = ts_sec_i;
        new_rec.hit = hits;
        new_rec.cyc = ts_cyc_i;
    end

    trig_rec_fifo #(
        .WIDTH (REC_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_req),
        .din_i   (new_rec),
        .pop_i   (pop),
        .dout_o  (head_rec),
        .empty_o (fifo_empty),
        .full_o  (fifo_full),
        .count_o (fifo_cnt)
    );

    trig_bus_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .stb_i        (bus_stb_i),
        .we_i         (bus_we_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .ack_o        (bus_ack_o),
        .rdata_o      (bus_rdata_o),
        .head_i       (head_rec),
        .empty_i      (fifo_empty),
        .drop_i       (push_req & fifo_full),
        .link_en_i    (link_en_i),
        .link_up_i    (link_up_i),
        .time_valid_i (time_valid_i),
        .en_o         (en),
        .pop_o        (pop),
        .dropped_o    (dropped)
    );

endmodule

// File: rtl/trig_event_log_chk.sv
// Protocol and queue checks for the trigger event logger, bound to the top.
module trig_event_log_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_stb_i,
    input logic             bus_we_i,
    input logic [4:0]       bus_addr_i,
    input logic             bus_ack_o,
    input logic [31:0]      bus_rdata_o,
    input logic             push_req,
    input logic             fifo_full,
    input logic             pop,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             dropped,
    input logic [4:0]       en
);

    p_ack_follows_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb_i |=> bus_ack_o);

    p_ack_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |-> $past(bus_stb_i));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    p_drop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full) |=> dropped);

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !push_req);

    p_empty_cyc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb_i && !bus_we_i && bus_addr_i[4:2] == 3'd4 && fifo_cnt == '0)
        |=> (bus_rdata_o == '0));

    p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_req) |=> (fifo_cnt == $past(fifo_cnt) - CNT_W'(1)));

endmodule

bind trig_event_log trig_event_log_chk #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_stb_i   (bus_stb_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_ack_o   (bus_ack_o),
    .bus_rdata_o (bus_rdata_o),
    .push_req    (push_req),
    .fifo_full   (fifo_full),
    .pop         (pop),
    .fifo_cnt    (fifo_cnt),
    .dropped     (dropped),
    .en          (en)
);

// File: tb/trig_event_log_bench.sv
module trig_event_log_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  trig;
    logic [39:0] sec;
    logic [27:0] cyc;
    logic        len, lup, tval;
    logic        stb, we;
    logic [4:0]  addr;
    logic [31:0] wdat;
    logic        ack;
    logic [31:0] rdat;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trig_event_log u_trig_event_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_in      (trig),
        .ts_sec_i     (sec),
        .ts_cyc_i     (cyc),
        .link_en_i    (len),
        .link_up_i    (lup),
        .time_valid_i (tval),
        .bus_stb_i    (stb),
        .bus_we_i     (we),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdat),
        .bus_ack_o    (ack),
        .bus_rdata_o  (rdat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        stb = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        stb = 1'b0;
        d = rdat;
        if (ack !== 1'b1) check("R9 read ack", {31'b0, ack}, 32'h1);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        stb = 1'b1; we = 1'b1; addr = a; wdat = d;
        @(negedge clk);
        stb = 1'b0; we = 1'b0;
        if (ack !== 1'b1) check("R9 write ack", {31'b0, ack}, 32'h1);
    endtask

    // Hold a trigger pattern for several system cycles, then release it
    task automatic fire(input logic [4:0] m);
        @(negedge clk);
        trig = m;
        repeat (4) @(negedge clk);
        trig = '0;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_of(input logic [4:0] m);
        return {23'b0, m[4], 4'b0, m[3:0]};
    endfunction

    function automatic logic [31:0] hi_of(input logic [4:0] m, input logic [39:0] s);
        return {7'b0, m[4], 4'b0, m[3:0], 8'b0, s[39:32]};
    endfunction

    task automatic expect_rec(input string req, input logic [4:0] m,
                              input logic [39:0] s, input logic [27:0] c);
        logic [31:0] d;
        bus_rd(5'h00, d);
        check({req, " present"}, {23'b0, d[8], 8'b0}, 32'h100);
        bus_rd(5'h08, d);
        check({req, " R4 hi"}, d, hi_of(m, s));
        bus_rd(5'h0C, d);
        check({req, " R4 lo"}, d, s[31:0]);
        bus_rd(5'h10, d);
        check({req, " R5 cyc"}, d, {4'b0, c});
    endtask

    task automatic expect_empty(input string req);
        logic [31:0] d;
        bus_rd(5'h00, d);
        check({req, " empty"}, {23'b0, d[8], 8'b0}, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd150000, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        trig = '0; sec = '0; cyc = '0; len = 0; lup = 0; tval = 0;
        stb = 0; we = 0; addr = '0; wdat = '0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R2, R6)
        bus_rd(5'h04, d);
        check("R2 ctrl after reset", d, 32'h0);
        bus_rd(5'h00, d);
        check("R6 status after reset", d, 32'h0);

        // Nothing enabled: no record (R2)
        sec = 40'h12_3456_789A; cyc = 28'h0123456;
        fire(5'h1F);
        expect_empty("R2 disabled");

        // Control readback keeps only enable bits (R2, R8)
        bus_wr(5'h04, 32'hFFFF_FFFF);
        bus_rd(5'h04, d);
        check("R8 ctrl unused bits", d, 32'h0000_010F);

        // Status link mirror sweep (R6)
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {tval, lup, len} = 3'(i);
            bus_rd(5'h00, d);
            check("R6 link bits", d, 32'(i));
        end
        {tval, lup, len} = 3'b0;

        // Empty-queue and unmapped reads (R8)
        bus_rd(5'h08, d); check("R8 empty hi", d, 32'h0);
        bus_rd(5'h0C, d); check("R8 empty lo", d, 32'h0);
        bus_rd(5'h10, d); check("R8 empty cyc", d, 32'h0);
        bus_rd(5'h14, d); check("R8 unmapped 0x14", d, 32'h0);
        bus_rd(5'h18, d); check("R8 unmapped 0x18", d, 32'h0);
        bus_rd(5'h1C, d); check("R8 unmapped 0x1C", d, 32'h0);
        expect_empty("R8 empty cyc read no pop");

        // Enable sweep with every source firing (R2, R3)
        for (int e = 0; e < 32; e++) begin
            bus_wr(5'h04, ctrl_of(5'(e)));
            sec = 40'hA5_0000_0000 + 40'(e * 40'h1_0001);
            cyc = 28'h0ABC000 + 28'(e);
            fire(5'h1F);
            if (e != 0) expect_rec("R3 enable sweep", 5'(e), sec, cyc);
            expect_empty("R3 enable sweep single record");
        end

        // Fire-pattern sweep with all enabled, held level gives one record (R1, R3)
        bus_wr(5'h04, 32'h0000_010F);
        for (int m = 1; m < 32; m++) begin
            sec = 40'h3C_8000_0000 + 40'(m * 7);
            cyc = 28'h5000000 + 28'(m * 3);
            fire(5'(m));
            expect_rec("R1 fire sweep", 5'(m), sec, cyc);
            expect_empty("R1 one record per edge");
        end

        // Show-ahead head stable across reads, writes to record words ignored (R4, R9)
        sec = 40'hFE_DCBA_9876; cyc = 28'h0FEDCBA;
        fire(5'h05);
        bus_wr(5'h08, 32'hFFFF_FFFF);
        bus_wr(5'h10, 32'hFFFF_FFFF);
        bus_rd(5'h08, d); check("R4 hi read 1", d, hi_of(5'h05, sec));
        bus_rd(5'h08, d); check("R4 hi read 2", d, hi_of(5'h05, sec));
        bus_rd(5'h0C, d); check("R9 lo after write", d, sec[31:0]);
        bus_rd(5'h10, d); check("R5 cyc pop", d, {4'b0, cyc});
        expect_empty("R5 after pop");

        // Fill to capacity, overflow drop and order (R7, R10)
        for (int k = 0; k < 18; k++) begin
            sec = 40'h01_0000_0000 + 40'(k);
            cyc = 28'h0000100 + 28'(k);
            fire(5'(1 << (k % 5)));
            if (k == 15) begin
                bus_rd(5'h00, d);
                check("R7 full no drop yet", d, 32'h100);
            end
        end
        bus_rd(5'h00, d);
        check("R7 drop sticky", d, 32'h300);
        bus_wr(5'h00, 32'h0000_0000);
        bus_rd(5'h00, d);
        check("R7 write 0 keeps drop", d, 32'h300);
        for (int k = 0; k < 16; k++) begin
            expect_rec("R10 order", 5'(1 << (k % 5)), 40'h01_0000_0000 + 40'(k),
                       28'h0000100 + 28'(k));
        end
        expect_empty("R7 extras dropped");
        bus_rd(5'h00, d);
        check("R7 drop kept after drain", d, 32'h200);
        bus_wr(5'h00, 32'h0000_0200);
        bus_rd(5'h00, d);
        check("R7 drop cleared", d, 32'h0);

        // Ack lasts one cycle (R9)
        @(negedge clk);
        check("R9 ack idle", {31'b0, ack}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule